// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller with Lock and Flash Clear

This block is the tag and state side of a small set-associative level-one cache. For every set it keeps a valid bit and a stored tag for each way, plus a next-victim pointer. For each core access it decides whether the access hits, misses and fills a line with a burst, or goes out as a single-beat bus transaction that leaves the cache untouched. The data array and any write-back path sit outside the block. The block only reports which way was hit or chosen for the fill.

Three control inputs shape the behaviour. The enable input turns the whole tag state on or off. The lock input freezes the contents, so hits still return data but misses no longer fill. A flash-clear write starts a sweep that visits one set per clock. The sweep clears every valid bit and resets every victim pointer to way 0, and core accesses are held off while it runs. A snoop port can invalidate a matching line. This works even when the cache is locked, and a line removed that way cannot come back until the lock is released.

Top module: `l1_tag_ctrl`

## Requirements
- R1: After reset every outputs is 0 and every line is invalid, so the first cacheable access to any set misses.
- R2: While `cfg_enable` is 0, each accepted access answers with `rsp_hit`=0, `bus_req`=1 and `bus_burst`=0, and `bus_inhibit` equals `req_inhibit`; the tag state is neither read nor changed, and snoops answer with `snp_hit`=0 and invalidate nothing.
- R3: While enabled and unlocked, a non-inhibited access that misses answers with `bus_req`=1 and `bus_burst`=1 and fills the victim way of its set, so a repeat of the same set and tag then hits with `bus_req`=0; a burst is never marked inhibited.
- R4: An access with `req_inhibit`=1 never hits and never fills; it answers with `bus_req`=1, `bus_burst`=0 and `bus_inhibit`=1.
- R5: While `cfg_lock` is 1, a hit answers normally, and a miss answers with a single beat carrying `req_inhibit` on `bus_inhibit`, without filling, so repeating it misses again.
- R6: A snoop whose set and tag match a valid way answers with `snp_hit`=1 one cycle later and clears that way, even under lock; under lock that line then keeps missing, and after unlock it refills with a burst.
- R7: The victim pointer of a set moves to (way+1) mod WAYS after a hit on that way or a fill into it; a fill goes into the way the pointer names, and `rsp_way` reports the way hit or filled.
- R8: A write on `fi_write` raises `fi_pending` on the next cycle, and it drops again on the cycle after that.
- R9: When `fi_pending` is 1 and `cfg_enable` is 1, the next cycle raises `inval_start` for one cycle and `busy` for exactly SETS cycles; after `busy` falls, every set, including the last, is invalid.
- R10: While `busy` is 1, core requests get no response and change nothing, and snoops answer with `snp_rsp_valid`=1 and `snp_hit`=0.
- R11: After a sweep every victim pointer names way 0, so the next fill into any set reports `rsp_way`=0.
- R12: If `cfg_enable` is 0 when `fi_pending` is 1, the request is dropped: `busy` and `inval_start` stay 0 and the cache contents survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Cache enable |
| cfg_lock | input | 1 | Cache lock |
| fi_write | input | 1 | Write of 1 to the flash-clear request bit |
| fi_pending | output | 1 | Flash-clear request bit, clears by itself |
| req_valid | input | 1 | Core access request |
| req_set | input | SET_W | Set index of the access |
| req_tag | input | TAG_W | Tag of the access |
| req_inhibit | input | 1 | Cache-inhibit attribute from translation |
| rsp_valid | output | 1 | Access response, one cycle after acceptance |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | WAY_W | Way hit or filled |
| bus_req | output | 1 | Bus transaction needed |
| bus_burst | output | 1 | 1: line fill burst, 0: single beat |
| bus_inhibit | output | 1 | Inhibit attribute for the bus transaction |
| busy | output | 1 | Flash-clear sweep in progress; core is stalled |
| inval_start | output | 1 | One-cycle pulse when a sweep begins |
| snp_valid | input | 1 | Snoop request |
| snp_set | input | SET_W | Snoop set index |
| snp_tag | input | TAG_W | Snoop tag |
| snp_rsp_valid | output | 1 | Snoop response, one cycle after the request |
| snp_hit | output | 1 | Snoop matched and invalidated a line |

## Verification
A valid bit left set or cleared in error shows up on the next access to that set. It answers with the wrong hit flag, and also with a burst where a single beat was due, or the other way round. A victim pointer that drifts shows up only at the next fill into its set, as a wrong `rsp_way`, so the bench fills a set several times after chosen hit orders. A short or partial sweep shows up as a wrong `busy` length, or as a hit on the first and last sets straight after `busy` falls.

// File: rtl/l1tc_pkg.sv
package l1tc_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_HIT,
    ACC_FILL,
    ACC_SINGLE
  } acc_kind_e;
endpackage

// File: rtl/l1tc_way_store.sv
module l1tc_way_store #(
  parameter int SETS  = 32,
  parameter int TAG_W = 8,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic [SET_W-1:0] sn_set,
  input  logic [TAG_W-1:0] sn_tag,
  output logic             sn_hit,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inv_en,
  input  logic [SET_W-1:0] inv_set,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set
);
  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [SETS];

  assign lk_hit = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
  assign sn_hit = vld_q[sn_set] && (tag_q[sn_set] == sn_tag);

  // sweep clear wins over fill, fill wins over snoop invalidate
  always_comb begin
    vld_d = vld_q;
    for (int s = 0; s < SETS; s++) begin
      if (inv_en && inv_set == SET_W'(s))
        vld_d[s] = 1'b0;
      if (fill_en && fill_set == SET_W'(s))
        vld_d[s] = 1'b1;
      if (clr_en && clr_set == SET_W'(s))
        vld_d[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set] <= fill_tag;
  end
endmodule

// File: rtl/l1tc_victim_ptr.sv
module l1tc_victim_ptr #(
  parameter int SETS  = 32,
  parameter int WAYS  = 2,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr_d [SETS];
  logic [WAY_W-1:0] away;

  assign rd_way = ptr_q[rd_set];
  assign away   = (upd_way == WAY_W'(WAYS - 1)) ? '0 : upd_way + 1'b1;

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      ptr_d[s] = ptr_q[s];
      if (upd_en && upd_set == SET_W'(s))
        ptr_d[s] = away;
      if (clr_en && clr_set == SET_W'(s))
        ptr_d[s] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= ptr_d[s];
    end
  end
endmodule

// File: rtl/l1tc_flash_seq.sv
module l1tc_flash_seq #(
  parameter int SETS  = 32,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fi_write,
  input  logic             enable,
  output logic             pending,
  output logic             busy,
  output logic             start,
  output logic             clr_en,
  output logic [SET_W-1:0] clr_set
);
  logic             pend_q, pend_d;
  logic             busy_q, busy_d;
  logic             start_q, start_d;
  logic [SET_W-1:0] idx_q, idx_d;
  logic             begin_op;

  always_comb begin
    pend_d   = fi_write;
    begin_op = pend_q && enable;
    start_d  = begin_op;
    busy_d   = busy_q;
    idx_d    = idx_q;
    if (begin_op) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == SET_W'(SETS - 1)) busy_d = 1'b0;
      else                           idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      idx_q   <= idx_d;
    end
  end

  assign pending = pend_q;
  assign busy    = busy_q;
  assign start   = start_q;
  assign clr_en  = busy_q && !begin_op;
  assign clr_set = idx_q;
endmodule

// File: rtl/l1_tag_ctrl.sv
module l1_tag_ctrl
  import l1tc_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_lock,
  input  logic             fi_write,
  output logic             fi_pending,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_inhibit,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic             bus_req,
  output logic             bus_burst,
  output logic             bus_inhibit,
  output logic             busy,
  output logic             inval_start,
  input  logic             snp_valid,
  input  logic [SET_W-1:0] snp_set,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_rsp_valid,
  output logic             snp_hit
);
  logic [WAYS-1:0]  lk_hit_w, sn_hit_w;
  logic [WAY_W-1:0] victim, hit_way, upd_way;
  logic             clr_en;
  logic [SET_W-1:0] clr_set;
  logic             acc, any_hit, use_cache, fill_en, upd_en, snp_look;
  acc_kind_e        kind;

  logic             rsp_valid_d, rsp_hit_d, bus_req_d, bus_burst_d, bus_inh_d;
  logic [WAY_W-1:0] rsp_way_d;
  logic             snp_rsp_d, snp_hit_d;

  l1tc_flash_seq #(.SETS(SETS), .SET_W(SET_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fi_write(fi_write),
    .enable  (cfg_enable),
    .pending (fi_pending),
    .busy    (busy),
    .start   (inval_start),
    .clr_en  (clr_en),
    .clr_set (clr_set)
  );

  l1tc_victim_ptr #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_set (req_set),
    .rd_way (victim),
    .upd_en (upd_en),
    .upd_set(req_set),
    .upd_way(upd_way),
    .clr_en (clr_en),
    .clr_set(clr_set)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    l1tc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_set  (req_set),
      .lk_tag  (req_tag),
      .lk_hit  (lk_hit_w[g]),
      .sn_set  (snp_set),
      .sn_tag  (snp_tag),
      .sn_hit  (sn_hit_w[g]),
      .fill_en (fill_en && (victim == WAY_W'(g))),
      .fill_set(req_set),
      .fill_tag(req_tag),
      .inv_en  (snp_look && sn_hit_w[g]),
      .inv_set (snp_set),
      .clr_en  (clr_en),
      .clr_set (clr_set)
    );
  end

  // access classification
  always_comb begin
    acc       = req_valid && !busy;
    any_hit   = |lk_hit_w;
    use_cache = cfg_enable && !req_inhibit;
    hit_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (lk_hit_w[w]) hit_way = WAY_W'(w);
    kind = ACC_IDLE;
    if (acc) begin
      if (use_cache && any_hit)       kind = ACC_HIT;
      else if (use_cache && !cfg_lock) kind = ACC_FILL;
      else                            kind = ACC_SINGLE;
    end
    fill_en = (kind == ACC_FILL);
    upd_en  = (kind == ACC_HIT) || (kind == ACC_FILL);
    upd_way = (kind == ACC_HIT) ? hit_way : victim;
    snp_look = snp_valid && cfg_enable && !busy;
  end

  // response next state
  always_comb begin
    rsp_valid_d = acc;
    rsp_hit_d   = (kind == ACC_HIT);
    bus_req_d   = (kind == ACC_FILL) || (kind == ACC_SINGLE);
    bus_burst_d = (kind == ACC_FILL);
    bus_inh_d   = (kind == ACC_SINGLE) && req_inhibit;
    rsp_way_d   = upd_en ? upd_way : '0;
    snp_rsp_d   = snp_valid;
    snp_hit_d   = snp_look && (|sn_hit_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      bus_req       <= 1'b0;
      bus_burst     <= 1'b0;
      bus_inhibit   <= 1'b0;
      snp_rsp_valid <= 1'b0;
      snp_hit       <= 1'b0;
    end else begin
      rsp_valid     <= rsp_valid_d;
      rsp_hit       <= rsp_hit_d;
      rsp_way       <= rsp_way_d;
      bus_req       <= bus_req_d;
      bus_burst     <= bus_burst_d;
      bus_inhibit   <= bus_inh_d;
      snp_rsp_valid <= snp_rsp_d;
      snp_hit       <= snp_hit_d;
    end
  end
endmodule

// File: rtl/l1_tag_ctrl_sva.sv
module l1_tag_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_lock,
  input logic fi_write,
  input logic fi_pending,
  input logic req_valid,
  input logic req_inhibit,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic bus_req,
  input logic bus_burst,
  input logic bus_inhibit,
  input logic busy,
  input logic inval_start,
  input logic snp_valid,
  input logic snp_rsp_valid,
  input logic snp_hit
);
  AST_BUSY_BLOCKS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid); // R10
  AST_BUSY_SNOOP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !snp_hit); // R10
  AST_OFF_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !cfg_enable |=> rsp_valid && bus_req && !bus_burst && !rsp_hit); // R2
  AST_OFF_SNOOP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !cfg_enable |=> snp_rsp_valid && !snp_hit); // R2
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && !bus_req); // R3
  AST_BURST_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> bus_req && !bus_inhibit); // R3
  AST_INHIBIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_inhibit |=> !rsp_hit && bus_req && !bus_burst && bus_inhibit); // R4
  AST_LOCK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && cfg_lock |=> !bus_burst); // R5
  AST_FLAG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fi_pending && !fi_write |=> !fi_pending); // R8
  AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    inval_start |-> busy); // R9
  AST_BUSY_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> inval_start); // R9
endmodule

bind l1_tag_ctrl l1_tag_ctrl_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_lock     (cfg_lock),
  .fi_write     (fi_write),
  .fi_pending   (fi_pending),
  .req_valid    (req_valid),
  .req_inhibit  (req_inhibit),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .bus_req      (bus_req),
  .bus_burst    (bus_burst),
  .bus_inhibit  (bus_inhibit),
  .busy         (busy),
  .inval_start  (inval_start),
  .snp_valid    (snp_valid),
  .snp_rsp_valid(snp_rsp_valid),
  .snp_hit      (snp_hit)
);

// File: tb/l1_tag_ctrl_bench.sv
module l1_tag_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETS  = 32;
  localparam int WAYS  = 2;
  localparam int TAG_W = 8;
  localparam int SET_W = 5;
  localparam int WAY_W = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable, cfg_lock, fi_write, fi_pending;
  logic req_valid, req_inhibit;
  logic [SET_W-1:0] req_set, snp_set;
  logic [TAG_W-1:0] req_tag, snp_tag;
  logic rsp_valid, rsp_hit, bus_req, bus_burst, bus_inhibit, busy, inval_start;
  logic [WAY_W-1:0] rsp_way;
  logic snp_valid, snp_rsp_valid, snp_hit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  l1_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_l1_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
    .fi_write(fi_write), .fi_pending(fi_pending),
    .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag), .req_inhibit(req_inhibit),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .bus_req(bus_req), .bus_burst(bus_burst), .bus_inhibit(bus_inhibit),
    .busy(busy), .inval_start(inval_start),
    .snp_valid(snp_valid), .snp_set(snp_set), .snp_tag(snp_tag),
    .snp_rsp_valid(snp_rsp_valid), .snp_hit(snp_hit)
  );

  typedef struct {
    logic  hit;
    logic  bus;
    logic  burst;
    logic  inh;
    int    way;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "hit",   int'(rsp_hit),     int'(e.hit));
        chk(e.req, "bus",   int'(bus_req),     int'(e.bus));
        chk(e.req, "burst", int'(bus_burst),   int'(e.burst));
        chk(e.req, "inh",   int'(bus_inhibit), int'(e.inh));
        chk(e.req, "way",   int'(rsp_way),     e.way);
      end
    end
  end

  // driver: pushes the expected result, drives one request cycle
  task automatic access(input int s, input int t, input logic inh,
                        input logic e_hit, input logic e_bus, input logic e_burst,
                        input logic e_inh, input int e_way, input string req);
    exp_t e;
    @(negedge clk);
    req_set = SET_W'(s); req_tag = TAG_W'(t); req_inhibit = inh; req_valid = 1'b1;
    e.hit = e_hit; e.bus = e_bus; e.burst = e_burst; e.inh = e_inh; e.way = e_way; e.req = req;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic snoop(input int s, input int t, input logic e_hit, input string req);
    @(negedge clk);
    snp_set = SET_W'(s); snp_tag = TAG_W'(t); snp_valid = 1'b1;
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    chk(req, "snoop rsp valid", int'(snp_rsp_valid), 1);
    chk(req, "snoop hit", int'(snp_hit), int'(e_hit));
  endtask

  task automatic flash(input logic en);
    int n;
    @(negedge clk);
    fi_write = 1'b1;
    @(posedge clk); #1;
    fi_write = 1'b0;
    @(negedge clk);
    chk("R8", "pending set", int'(fi_pending), 1);
    chk("R9", "busy before start", int'(busy), 0);
    @(negedge clk);
    chk("R8", "pending cleared", int'(fi_pending), 0);
    if (en) begin
      chk("R9", "busy", int'(busy), 1);
      chk("R9", "start pulse", int'(inval_start), 1);
      req_set = 5'd3; req_tag = 8'h66; req_inhibit = 1'b0; req_valid = 1'b1;
      snp_set = 5'd3; snp_tag = 8'h66; snp_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0; snp_valid = 1'b0;
      @(negedge clk);
      chk("R10", "blocked core rsp", int'(rsp_valid), 0);
      chk("R10", "snoop rsp valid", int'(snp_rsp_valid), 1);
      chk("R10", "snoop miss in sweep", int'(snp_hit), 0);
      chk("R9", "start one cycle", int'(inval_start), 0);
      n = 2;
      @(negedge clk);
      while (busy && n < SETS + 10) begin
        n++;
        @(negedge clk);
      end
      chk("R9", "busy cycles", n, SETS);
    end else begin
      chk("R12", "no busy", int'(busy), 0);
      chk("R12", "no start", int'(inval_start), 0);
      @(negedge clk);
      chk("R12", "still idle", int'(busy), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      chk("WATCHDOG", "timeout", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_lock = 1'b0; fi_write = 1'b0;
    req_valid = 1'b0; req_set = '0; req_tag = '0; req_inhibit = 1'b0;
    snp_valid = 1'b0; snp_set = '0; snp_tag = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1", "bus_req in reset", int'(bus_req), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "pending in reset", int'(fi_pending), 0);
    chk("R1", "snp_hit in reset", int'(snp_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "start after reset", int'(inval_start), 0);

    // disabled: single beats, attribute passed
    access(3, 'h11, 1'b0, 0, 1, 0, 0, 0, "R2");
    access(3, 'h11, 1'b1, 0, 1, 0, 1, 0, "R2");

    // enabled fill and hit
    cfg_enable = 1'b1;
    access(3, 'h11, 1'b0, 0, 1, 1, 0, 0, "R1");
    access(3, 'h11, 1'b0, 1, 0, 0, 0, 0, "R3");
    access(3, 'h22, 1'b0, 0, 1, 1, 0, 1, "R7");
    access(3, 'h11, 1'b0, 1, 0, 0, 0, 0, "R3");
    access(3, 'h22, 1'b0, 1, 0, 0, 0, 1, "R7");
    access(3, 'h33, 1'b0, 0, 1, 1, 0, 0, "R7");
    access(3, 'h22, 1'b0, 1, 0, 0, 0, 1, "R7");
    access(3, 'h11, 1'b0, 0, 1, 1, 0, 0, "R7");

    // inhibited accesses
    access(3, 'h11, 1'b1, 0, 1, 0, 1, 0, "R4");
    access(5, 'h44, 1'b1, 0, 1, 0, 1, 0, "R4");
    access(5, 'h44, 1'b0, 0, 1, 1, 0, 0, "R4");

    // snoop ignored while disabled
    cfg_enable = 1'b0;
    snoop(3, 'h22, 1'b0, "R2");
    cfg_enable = 1'b1;
    access(3, 'h22, 1'b0, 1, 0, 0, 0, 1, "R2");

    // lock
    cfg_lock = 1'b1;
    access(3, 'h11, 1'b0, 1, 0, 0, 0, 0, "R5");
    access(7, 'h55, 1'b0, 0, 1, 0, 0, 0, "R5");
    access(7, 'h55, 1'b0, 0, 1, 0, 0, 0, "R5");

    // snoop under lock
    snoop(3, 'h11, 1'b1, "R6");
    access(3, 'h11, 1'b0, 0, 1, 0, 0, 0, "R6");
    cfg_lock = 1'b0;
    access(3, 'h11, 1'b0, 0, 1, 1, 0, 1, "R6");
    snoop(3, 'h99, 1'b0, "R6");

    // prepare pointers at 1 before the sweep
    access(3, 'h66, 1'b0, 0, 1, 1, 0, 0, "R7");
    access(31, 'h77, 1'b0, 0, 1, 1, 0, 0, "R7");
    flash(1'b1);
    access(3, 'h66, 1'b0, 0, 1, 1, 0, 0, "R11");
    access(31, 'h77, 1'b0, 0, 1, 1, 0, 0, "R9");

    // sweep request while disabled is dropped
    cfg_enable = 1'b0;
    flash(1'b0);
    cfg_enable = 1'b1;
    access(3, 'h66, 1'b0, 1, 0, 0, 0, 0, "R12");

    @(negedge clk);
    @(negedge clk);
    chk("R3", "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule